// File: doc/BRIEF.md
# Four-Lane Receive Deskew Aligner

This block sits behind the code-group decoders of a four-lane 10-gigabit attachment-unit receiver. Each lane delivers one decoded byte per cycle together with a control flag and a valid bit that says the lane already holds code-group synchronisation. Wire and serialiser skew make the same transmitted column arrive on the four lanes in different cycles. The block buffers every lane in its own small FIFO and moves the read points so that the periodic alignment character, /A/ (K28.3: byte 0x7C with the control flag set), leaves all four lanes in the same output column.

During the search each lane discards bytes until /A/ reaches its FIFO head and then stalls there. Once all four lanes stall on /A/, the lanes are released together and from then on move in lockstep. An aligned flag gives the result with hysteresis. It is raised after four output columns with /A/ on every lane, and it is cleared after four consecutive output columns in which only some lanes carry /A/. Clearing it restarts the search. A lane that waits too long, or a lane that drops its valid bit, flushes all buffers and restarts the search.

Top module: `lane_deskew_x4`

## Requirements
- R1: While reset is held, `dsk_aligned`, `dsk_vld`, `dsk_byte` and `dsk_k` are all zero.
- R2: Each lane stores its byte and control flag in a 16-entry FIFO in any cycle its valid bit is high, and the symbols leave in arrival order. Consecutive non-/A/ columns on the output carry consecutive byte values when the input lanes carry an incrementing byte sequence.
- R3: While searching, a lane whose FIFO head is /A/ (byte 0x7C, control flag 1) holds. Other lanes drop their head symbol each cycle. `dsk_vld` stays low, so the first column that leaves after a search is an all-/A/ column.
- R4: In the cycle after all four FIFO heads are /A/, all lanes pop together and keep popping in lockstep. Output lane g occupies bits [8g+7:8g] of `dsk_byte` and bit g of `dsk_k`. Every output column then holds the same symbol on all four lanes.
- R5: `dsk_aligned` rises in the same cycle that the fourth all-/A/ output column since the search ended is presented on the outputs.
- R6: A misaligned /A/ event is an output column where one to three lanes carry /A/. An all-/A/ column resets the event count. `dsk_aligned` stays high through three consecutive events and falls in the cycle the fourth is presented on the outputs. The search then restarts and later re-aligns on the new skew.
- R7: If a lane holds /A/ for 12 cycles while the search is not complete, all FIFOs are flushed and the search restarts. No output column is produced and `dsk_aligned` stays low while one lane never sends /A/.
- R8: If any bit of `rx_lane_vld` is low in a cycle, all FIFOs are flushed, the search restarts, and in the next cycle `dsk_aligned` and `dsk_vld` are low.
- R9: Any lane-to-lane skew from 0 to 7 cycles is removed, giving R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_lane_vld | input | 4 | Per-lane valid, high when the lane is in code-group sync |
| rx_lane_byte | input | 32 | Decoded bytes, lane g in bits [8g+7:8g] |
| rx_lane_k | input | 4 | Per-lane control flag, lane g in bit g |
| dsk_vld | output | 1 | An aligned column is on `dsk_byte`/`dsk_k` |
| dsk_byte | output | 32 | Deskewed bytes, lane g in bits [8g+7:8g] |
| dsk_k | output | 4 | Deskewed control flags |
| dsk_aligned | output | 1 | All four lanes aligned, with hysteresis |

## Verification
The hardest situations to reach are the ones where alignment is already held: the hysteresis drop and the wait-limit flush. Both need the lane streams to change relative to each other while /A/ columns keep arriving. The stimulus feeds each lane a delayed copy of one incrementing column stream with a periodic /A/. It first lets the block lock, then inserts one repeated symbol into a single lane between two /A/ columns, which splits every later /A/ column into two misaligned events. For the wait limit, /A/ is replaced by data on one lane only. The other three lanes then hold and time out repeatedly, and the bench then checks that the block re-aligns cleanly once that lane sends /A/ again.

// File: rtl/deskew_pkg.sv
// Shared types for the four-lane deskew aligner.
// Assumes decoded symbols: an 8-bit byte plus a control flag.
package deskew_pkg;

    localparam int NUM_LANES = 4;
    localparam logic [7:0] ALIGN_BYTE = 8'h7C;

    // One decoded symbol; ctrl set marks a control code group.
    typedef struct packed {
        logic       ctrl;
        logic [7:0] data;
    } sym_t;

    // Search versus lockstep operation of the read side.
    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RUN  = 1'b1
    } dsk_state_e;

    // True when the symbol is the alignment code group.
    function automatic logic is_align(input sym_t s);
        return s.ctrl && (s.data == ALIGN_BYTE);
    endfunction

endpackage

// File: rtl/deskew_fifo.sv
// Per-lane deskew buffer: a fall-through FIFO of decoded symbols.
// The head symbol is visible combinationally. The flush input empties
// the FIFO and drops any write in the same cycle. Assumes the caller
// keeps occupancy below DEPTH; the assertion below guards that.
module deskew_fifo
    import deskew_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic wr_en,
    input  sym_t wr_sym,
    input  logic rd_en,
    output sym_t head,
    output logic empty,
    output logic full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    sym_t          mem [DEPTH];
    logic [AW-1:0] wp_q;
    logic [AW-1:0] rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_rd;
    logic          do_wr;

    // Advance a pointer with wrap at the configured depth.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    // Qualify the requested read and write against state and flush.
    always_comb begin
        do_rd = rd_en && !empty && !flush;
        do_wr = wr_en && !flush && (!full || do_rd);
    end

    // Storage array, written at the write pointer.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wp_q] <= wr_sym;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wp_q <= bump(wp_q);
            if (do_rd) rp_q <= bump(rp_q);
            case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Status and head view.
    always_comb begin
        empty = (cnt_q == '0);
        full  = (cnt_q == CW'(DEPTH));
        head  = mem[rp_q];
    end

    // R2: the controller never pops an empty lane.
    p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !flush) |-> !empty);

    // R7: the wait limit keeps every lane from overrunning its buffer.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |-> (rd_en || flush));

    // R2: occupancy never exceeds the depth.
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/deskew_ctrl.sv
// Read-side controller. In HUNT it pops lanes whose head is not /A/
// and holds lanes sitting on /A/. When all lanes hold, it switches to
// RUN and pops all lanes together from the next cycle on. A hold that
// lasts WAIT_LIMIT cycles, or a lane losing its valid bit, flushes all
// FIFOs. A restart request from the status monitor returns to HUNT.
module deskew_ctrl
    import deskew_pkg::*;
#(
    parameter int LANES      = NUM_LANES,
    parameter int WAIT_LIMIT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lanes_ok,
    input  logic [LANES-1:0] head_a,
    input  logic [LANES-1:0] empty,
    input  logic             restart,
    output logic [LANES-1:0] pop,
    output logic             flush,
    output logic             run
);

    localparam int WW = $clog2(WAIT_LIMIT + 1);
    localparam logic [WW-1:0] WAIT_LAST = WW'(WAIT_LIMIT - 1);

    dsk_state_e       st_q;
    dsk_state_e       st_d;
    logic [WW-1:0]    wait_q;
    logic [WW-1:0]    wait_d;
    logic [LANES-1:0] hold;
    logic             all_hold;
    logic             any_hold;
    logic             all_avail;
    logic             timeout;

    // Lane summaries used by both states.
    always_comb begin
        hold      = head_a & ~empty;
        all_hold  = &hold;
        any_hold  = |hold;
        all_avail = ~|empty;
        timeout   = (st_q == ST_HUNT) && any_hold && !all_hold && (wait_q == WAIT_LAST);
        flush     = !lanes_ok || timeout;
        run       = (st_q == ST_RUN);
    end

    // Next state, wait counter and per-lane pop decisions.
    always_comb begin
        st_d   = st_q;
        wait_d = wait_q;
        pop    = '0;
        if (flush) begin
            st_d   = ST_HUNT;
            wait_d = '0;
        end else if (st_q == ST_HUNT) begin
            if (all_hold) begin
                st_d   = ST_RUN;
                wait_d = '0;
            end else begin
                pop    = ~empty & ~head_a;
                wait_d = any_hold ? wait_q + WW'(1) : '0;
            end
        end else begin
            if (all_avail) pop = '1;
            if (restart)   st_d = ST_HUNT;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_HUNT;
            wait_q <= '0;
        end else begin
            st_q   <= st_d;
            wait_q <= wait_d;
        end
    end

    // R7: a hold never outlasts the configured wait limit.
    p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q < WW'(WAIT_LIMIT));

    // R3: a lane parked on /A/ during the search is never popped.
    p_hunt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HUNT) |-> ((pop & hold) == '0));

endmodule

// File: rtl/align_monitor.sv
// Alignment status with hysteresis. It looks at each column as it is
// popped. MATCH all-/A/ columns raise the status. MISS consecutive
// partial-/A/ columns drop it and request a restart of the search.
// An abort (flush) clears all counters and the status.
module align_monitor #(
    parameter int LANES = 4,
    parameter int MATCH = 4,
    parameter int MISS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             col_valid,
    input  logic [LANES-1:0] col_a,
    output logic             aligned,
    output logic             restart
);

    localparam int GW = $clog2(MATCH + 1);
    localparam int BW = $clog2(MISS + 1);

    logic [GW-1:0] good_q;
    logic [BW-1:0] bad_q;
    logic          full_a;
    logic          part_a;

    // Classify the column being popped and detect the final miss.
    always_comb begin
        full_a  = col_valid && (&col_a);
        part_a  = col_valid && (|col_a) && !(&col_a);
        restart = part_a && (bad_q == BW'(MISS - 1));
    end

    // Good and bad column counters and the status flag.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            good_q  <= '0;
            bad_q   <= '0;
            aligned <= 1'b0;
        end else if (restart) begin
            good_q  <= '0;
            bad_q   <= '0;
            aligned <= 1'b0;
        end else if (full_a) begin
            bad_q <= '0;
            if (good_q == GW'(MATCH - 1)) begin
                aligned <= 1'b1;
            end
            if (good_q != GW'(MATCH)) begin
                good_q <= good_q + GW'(1);
            end
        end else if (part_a) begin
            bad_q <= bad_q + BW'(1);
        end
    end

    // R6: the status only falls through an abort or a miss restart.
    p_drop_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aligned) |-> ($past(abort) || $past(restart)));

endmodule

// File: rtl/lane_deskew_x4.sv
// Top of the four-lane deskew aligner. It has one FIFO per lane,
// the read controller and the status monitor. The output column is
// registered. Assumes each lane's valid bit means code-group sync.
module lane_deskew_x4
    import deskew_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int WAIT_LIMIT = DEPTH - 4,
    parameter int MATCH      = 4,
    parameter int MISS       = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LANES-1:0]   rx_lane_vld,
    input  logic [8*NUM_LANES-1:0] rx_lane_byte,
    input  logic [NUM_LANES-1:0]   rx_lane_k,
    output logic                   dsk_vld,
    output logic [8*NUM_LANES-1:0] dsk_byte,
    output logic [NUM_LANES-1:0]   dsk_k,
    output logic                   dsk_aligned
);

    localparam int LANES = NUM_LANES;

    sym_t             lane_in   [LANES];
    sym_t             lane_head [LANES];
    logic [LANES-1:0] lane_empty;
    logic [LANES-1:0] lane_full;
    logic [LANES-1:0] lane_head_a;
    logic [LANES-1:0] lane_pop;
    logic             flush;
    logic             run;
    logic             restart;
    logic             col_valid;
    logic             lanes_ok;

    // All lanes must hold code-group sync.
    always_comb lanes_ok = &rx_lane_vld;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Pack the lane input into one symbol.
        assign lane_in[g] = {rx_lane_k[g], rx_lane_byte[8*g +: 8]};

        deskew_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (flush),
            .wr_en  (rx_lane_vld[g]),
            .wr_sym (lane_in[g]),
            .rd_en  (lane_pop[g]),
            .head   (lane_head[g]),
            .empty  (lane_empty[g]),
            .full   (lane_full[g])
        );

        // Flag lanes whose head is the alignment character.
        assign lane_head_a[g] = is_align(lane_head[g]);
    end

    deskew_ctrl #(.LANES(LANES), .WAIT_LIMIT(WAIT_LIMIT)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .lanes_ok (lanes_ok),
        .head_a   (lane_head_a),
        .empty    (lane_empty),
        .restart  (restart),
        .pop      (lane_pop),
        .flush    (flush),
        .run      (run)
    );

    // A column leaves only when every lane pops in lockstep.
    always_comb col_valid = run && (&lane_pop);

    align_monitor #(.LANES(LANES), .MATCH(MATCH), .MISS(MISS)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (flush),
        .col_valid (col_valid),
        .col_a     (lane_head_a),
        .aligned   (dsk_aligned),
        .restart   (restart)
    );

    // Output column register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsk_vld  <= 1'b0;
            dsk_byte <= '0;
            dsk_k    <= '0;
        end else begin
            dsk_vld <= col_valid;
            if (col_valid) begin
                for (int l = 0; l < LANES; l++) begin
                    dsk_byte[8*l +: 8] <= lane_head[l].data;
                    dsk_k[l]           <= lane_head[l].ctrl;
                end
            end
        end
    end

    // R4: during lockstep either every lane pops or none does.
    p_lockstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ((lane_pop == '0) || (&lane_pop)));

    // R5: the status rises together with an all-/A/ output column.
    p_rise_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dsk_aligned) |-> (dsk_vld && (&dsk_k) &&
            dsk_byte == {LANES{ALIGN_BYTE}}));

    // R8: losing sync on any lane clears the status next cycle.
    p_sync_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(&rx_lane_vld) |=> (!dsk_aligned && !dsk_vld));

endmodule

// File: tb/lane_deskew_x4_tb_top.sv
`timescale 1ns/1ps
module lane_deskew_x4_tb_top;

    localparam int P = 20;  // /A/ spacing in columns

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rx_lane_vld = '0;
    logic [31:0] rx_lane_byte = '0;
    logic [3:0]  rx_lane_k = '0;
    logic        dsk_vld;
    logic [31:0] dsk_byte;
    logic [3:0]  dsk_k;
    logic        dsk_aligned;

    lane_deskew_x4 dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_lane_vld  (rx_lane_vld),
        .rx_lane_byte (rx_lane_byte),
        .rx_lane_k    (rx_lane_k),
        .dsk_vld      (dsk_vld),
        .dsk_byte     (dsk_byte),
        .dsk_k        (dsk_k),
        .dsk_aligned  (dsk_aligned)
    );

    always #2.5 clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // stimulus state
    int   cyc = 0;
    int   skew [4] = '{0, 0, 0, 0};
    bit   kill_a [4] = '{0, 0, 0, 0};
    logic [3:0] vmask = 4'hF;

    // observation state
    int   n_allA, n_misA, n_vld, mism, seq_err;
    int   rise_allA, fall_misA;
    bit   rise_seen, fall_seen, eq_en, first_seen, first_allA;
    bit   prev_al = 0, prev_ok = 0;
    logic [7:0] prev_b = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_obs();
        n_allA = 0; n_misA = 0; n_vld = 0; mism = 0; seq_err = 0;
        rise_allA = 0; fall_misA = 0;
        rise_seen = 0; fall_seen = 0; first_seen = 0; first_allA = 0;
        prev_ok = 0;
    endtask

    // One clock: observe outputs, then drive the next input column.
    task automatic cycle();
        bit all_a, any_a, same;
        @(negedge clk);
        all_a = 1; any_a = 0; same = 1;
        for (int l = 0; l < 4; l++) begin
            bit a;
            a = dsk_k[l] && (dsk_byte[8*l +: 8] == 8'h7C);
            all_a = all_a && a;
            any_a = any_a || a;
            if (dsk_byte[8*l +: 8] != dsk_byte[7:0] || dsk_k[l] != dsk_k[0]) same = 0;
        end
        if (dsk_vld) begin
            n_vld++;
            if (!first_seen) begin first_seen = 1; first_allA = all_a; end
            if (all_a) n_allA++;
            if (any_a && !all_a) n_misA++;
            if (eq_en && !same) mism++;
            if (eq_en && !any_a && prev_ok && dsk_byte[7:0] != prev_b + 8'd1) seq_err++;
            prev_ok = !any_a;
            prev_b  = dsk_byte[7:0];
        end else begin
            prev_ok = 0;
        end
        if (dsk_aligned && !prev_al) begin rise_seen = 1; rise_allA = n_allA; end
        if (!dsk_aligned && prev_al) begin fall_seen = 1; fall_misA = n_misA; n_allA = 0; end
        prev_al = dsk_aligned;
        for (int l = 0; l < 4; l++) begin
            int t;
            t = cyc - skew[l];
            if (t < 0) begin
                rx_lane_byte[8*l +: 8] = 8'h00; rx_lane_k[l] = 1'b0;
            end else if ((t % P) == 0 && !kill_a[l]) begin
                rx_lane_byte[8*l +: 8] = 8'h7C; rx_lane_k[l] = 1'b1;
            end else begin
                rx_lane_byte[8*l +: 8] = t[7:0]; rx_lane_k[l] = 1'b0;
            end
        end
        rx_lane_vld = vmask;
        cyc++;
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic run_to_rise(input int lim);
        for (int i = 0; i < lim && !rise_seen; i++) cycle();
    endtask

    task automatic do_reset();
        rst_n = 0; vmask = 4'hF; rx_lane_vld = '0; rx_lane_byte = '0; rx_lane_k = '0;
        for (int l = 0; l < 4; l++) kill_a[l] = 0;
        eq_en = 0;
        repeat (3) @(negedge clk);
        check(dsk_aligned == 0, "R1", "aligned in reset", dsk_aligned, 0);
        check(dsk_vld == 0 && dsk_byte == 0 && dsk_k == 0, "R1", "outputs in reset", dsk_vld, 0);
        @(posedge clk); #1;
        rst_n = 1; cyc = 0; prev_al = 0;
        clear_obs();
    endtask

    // Lock with a fixed skew set, then check steady columns.
    task automatic test_skew(input int s0, input int s1, input int s2, input int s3);
        do_reset();
        skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
        run_to_rise(300);
        check(rise_seen, "R9", "aligned reached for skew set", rise_seen, 1);
        check(rise_allA == 4, "R5", "all-/A/ columns at rise", rise_allA, 4);
        check(first_allA, "R3", "first column after search is /A/", first_allA, 1);
        eq_en = 1; mism = 0; seq_err = 0; n_allA = 0; n_misA = 0;
        run_n(5 * P);
        check(mism == 0, "R4", "unequal lanes in columns", mism, 0);
        check(seq_err == 0, "R2", "byte order breaks", seq_err, 0);
        check(n_allA == 5 && n_misA == 0, "R4", "all-/A/ columns per window", n_allA, 5);
        check(dsk_aligned == 1, "R5", "aligned held", dsk_aligned, 1);
    endtask

    // Shift one lane by a symbol after lock and watch the hysteresis.
    task automatic test_misalign();
        test_skew(1, 2, 3, 4);
        eq_en = 0;
        while (((cyc - skew[2]) % P) != P / 2) cycle();
        skew[2] = skew[2] + 1;
        n_misA = 0; fall_seen = 0; rise_seen = 0;
        for (int i = 0; i < 6 * P && !fall_seen; i++) cycle();
        check(fall_seen, "R6", "aligned dropped", fall_seen, 1);
        check(fall_misA == 4, "R6", "misaligned events at drop", fall_misA, 4);
        run_to_rise(8 * P);
        check(rise_seen && rise_allA == 4, "R6", "re-aligned after restart", rise_allA, 4);
        eq_en = 1; mism = 0;
        run_n(3 * P);
        check(mism == 0, "R6", "unequal lanes after re-align", mism, 0);
    endtask

    // One lane never sends /A/: the others must time out and flush.
    task automatic test_timeout();
        do_reset();
        for (int l = 0; l < 4; l++) skew[l] = 0;
        kill_a[3] = 1;
        run_n(7 * P + 3);
        check(n_vld == 0, "R7", "columns while one lane lacks /A/", n_vld, 0);
        check(!rise_seen && dsk_aligned == 0, "R7", "aligned while one lane lacks /A/", dsk_aligned, 0);
        kill_a[3] = 0;
        run_to_rise(8 * P);
        check(rise_seen && rise_allA == 4, "R7", "aligned after /A/ returns", rise_allA, 4);
        eq_en = 1; mism = 0;
        run_n(3 * P);
        check(mism == 0, "R7", "unequal lanes after recovery", mism, 0);
    endtask

    // Drop one lane's valid bit while locked.
    task automatic test_sync_loss();
        test_skew(2, 0, 5, 1);
        eq_en = 0;
        vmask = 4'b1101;
        cycle();           // drives the low valid bit
        vmask = 4'hF;
        cycle();           // edge with low valid has passed
        check(dsk_aligned == 0, "R8", "aligned after sync loss", dsk_aligned, 1'b0);
        check(dsk_vld == 0, "R8", "column after sync loss", dsk_vld, 1'b0);
        rise_seen = 0; n_allA = 0;
        run_to_rise(8 * P);
        check(rise_seen && rise_allA == 4, "R8", "re-aligned after sync returns", rise_allA, 4);
        eq_en = 1; mism = 0;
        run_n(3 * P);
        check(mism == 0, "R8", "unequal lanes after sync returns", mism, 0);
    endtask

    initial begin
        test_skew(0, 0, 0, 0);
        test_skew(0, 3, 7, 5);
        test_skew(7, 0, 2, 6);
        test_skew(4, 7, 1, 0);
        test_misalign();
        test_timeout();
        test_sync_loss();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule